// File: doc/BRIEF.md
# Reduced-Precision Floating-Point Multiply Checker

This block watches a single-precision floating-point multiplier and tells whether the result that unit produced is believable. For each multiply it receives both 32-bit operands and the result claimed by the checked unit: that unit's result sign, its result exponent and its unrounded 48-bit significand product. It recomputes the sign and the exponent at full width. It then rebuilds only a coarse mantissa product by multiplying the top `CHK_BITS` bits of each 24-bit significand, where the significand is the stored 23-bit fraction with the hidden one prepended.

The two mantissa values are compared over a narrow window at the top of the product. A small fixed allowance absorbs the part of the product that the checker never computes. Any sign mismatch, exponent mismatch or out-of-allowance mantissa difference raises an error flag. Checking is switched off whenever an operand or the claimed result has a reserved exponent (all zeros or all ones), because the hidden-one assumption does not hold for those encodings.

The block has a two-register pipeline. The inputs are captured on a valid strobe, and the verdict comes out one cycle later with a single-cycle valid pulse. Larger `CHK_BITS` narrows the relative error that can slip through, at the cost of a bigger checker multiplier.

Top module: `fpmul_rp_checker`

## Requirements
- R1: Inputs are captured at a rising edge where `in_valid` is 1. `err_valid` is 1 for exactly one cycle, after the next rising edge. With no capture, `err_valid` stays 0. Back-to-back strobes give back-to-back verdicts in order.
- R2: `err_flag` is never 1 while `err_valid` is 0.
- R3: While `rst_n` is 0, both `err_valid` and `err_flag` go to 0 at the next rising edge. A multiply captured before the reset produces no verdict.
- R4: With checking enabled, `err_flag` is 1 when `res_sign` differs from bit 31 of `op_a` XOR bit 31 of `op_b`.
- R5: With checking enabled, `err_flag` is 1 when `res_exp` differs from the biased exponents of the operands (bits 30:23) summed, minus 127, plus bit 47 of `res_mant`. The sum is formed 10 bits wide so that it cannot wrap.
- R6: With checking enabled, let W be the top `CHK_BITS`+1 bits of `res_mant`. Let C be the top `CHK_BITS`+1 bits of the 2·`CHK_BITS`-bit product of the two significands' top `CHK_BITS` bits. `err_flag` is 1 exactly when the unsigned difference |W−C| exceeds `TOL` (default 7). For the defaults `CHK_BITS`=7, W is `res_mant[47:40]`.
- R7: Bits of `res_mant` below the window (bits 39:0 for the defaults) have no effect on `err_flag`.
- R8: When either operand or the claimed result has an exponent field of 0 (zero or denormal) or 255 (infinity or NaN), `err_flag` is 0 and `err_valid` still pulses.
- R9: An exact product of two normal operands, whose exponent lands in 1..254, with the correct sign and exponent, never raises `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture strobe for one multiply to be checked |
| op_a | input | 32 | First operand, single-precision encoding |
| op_b | input | 32 | Second operand, single-precision encoding |
| res_sign | input | 1 | Result sign claimed by the checked multiplier |
| res_exp | input | 8 | Biased result exponent claimed by the checked multiplier |
| res_mant | input | 48 | Unrounded significand product from the checked multiplier |
| err_valid | output | 1 | One-cycle pulse marking a verdict |
| err_flag | output | 1 | Mismatch found; meaningful only with `err_valid` |

## Verification
A multiply presented with `in_valid` before rising edge N is captured at N, and its verdict sits on `err_valid` and `err_flag` after edge N+1. The bench drives every input on a falling edge. It drops the strobe at the falling edge after N and reads both outputs at the falling edge after N+1, half a period clear of any active edge. It then looks at the next falling edge to confirm that the pulse lasted one cycle. The back-to-back and reset-abort scenarios step through the same edges one falling edge at a time, so that each verdict is read in the cycle it is due.

// File: rtl/fpck_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the unpacked-operand type for the
// reduced-precision multiply checker. Assumes IEEE single precision.
package fpck_pkg;
    localparam int WORD_W   = 32;
    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int PROD_W   = 2 * SIG_W;
    localparam int EXP_BIAS = 127;
    localparam int NUM_OPS  = 2;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic             special;
    } fp_fields_t;
endpackage

// File: rtl/fpck_unpack.sv
`timescale 1ns/1ps
// Module: fpck_unpack
// Splits one single-precision word into sign, exponent and a flag for
// reserved exponents, and returns the top CHK_BITS significand bits with
// the hidden one restored. Assumes a normal number when the flag is low.
module fpck_unpack
    import fpck_pkg::*;
#(
    parameter int CHK_BITS = 7
) (
    input  logic [WORD_W-1:0]   word,
    output fp_fields_t          fields,
    output logic [CHK_BITS-1:0] sig_hi
);
    localparam int FRAC_HI_BITS = CHK_BITS - 1;

    // Field split and reserved-exponent detection.
    always_comb begin
        fields.sign    = word[WORD_W-1];
        fields.exp     = word[WORD_W-2 -: EXP_W];
        fields.special = (fields.exp == '0) || (fields.exp == '1);
        sig_hi         = {1'b1, word[FRAC_W-1 -: FRAC_HI_BITS]};
    end
endmodule

// File: rtl/fpck_mant_cmp.sv
`timescale 1ns/1ps
// Module: fpck_mant_cmp
// Multiplies the two high significand slices and compares the top
// CHK_BITS+1 bits of that product with the same-weight window of the
// full product. Flags a difference above TOL. Assumes that the omitted
// cross and low terms shift the window by at most 5 units.
module fpck_mant_cmp #(
    parameter int CHK_BITS = 7,
    parameter int TOL      = 7
) (
    input  logic [CHK_BITS-1:0] a_hi,
    input  logic [CHK_BITS-1:0] b_hi,
    input  logic [CHK_BITS:0]   full_win,
    output logic                mant_bad
);
    localparam int PRD_W = 2 * CHK_BITS;
    localparam int WIN_W = CHK_BITS + 1;
    localparam logic [WIN_W-1:0] TOL_V = WIN_W'(TOL);

    logic [PRD_W-1:0] prod;
    logic [WIN_W-1:0] chk_win;
    logic [WIN_W-1:0] diff_mag;

    // Small checker multiply and absolute window difference.
    always_comb begin
        prod     = PRD_W'(a_hi) * PRD_W'(b_hi);
        chk_win  = prod[PRD_W-1 -: WIN_W];
        diff_mag = (full_win >= chk_win) ? (full_win - chk_win)
                                         : (chk_win - full_win);
        mant_bad = diff_mag > TOL_V;
    end
endmodule

// File: rtl/fpck_sgn_exp_cmp.sv
`timescale 1ns/1ps
// Module: fpck_sgn_exp_cmp
// Recomputes the product sign and biased exponent at full width and
// compares both with the claimed result. The exponent is widened by two
// bits so that overflow and underflow show up as mismatches.
module fpck_sgn_exp_cmp
    import fpck_pkg::*;
(
    input  fp_fields_t       opa,
    input  fp_fields_t       opb,
    input  logic             res_sign,
    input  logic [EXP_W-1:0] res_exp,
    input  logic             top_bit,
    output logic             sign_bad,
    output logic             exp_bad
);
    localparam int EXT_W = EXP_W + 2;

    logic [EXT_W-1:0] exp_sum;

    // Sign parity and normalised exponent comparison.
    always_comb begin
        sign_bad = res_sign != (opa.sign ^ opb.sign);
        exp_sum  = EXT_W'(opa.exp) + EXT_W'(opb.exp) + EXT_W'(top_bit)
                 - EXT_W'(EXP_BIAS);
        exp_bad  = exp_sum != EXT_W'(res_exp);
    end
endmodule

// File: rtl/fpmul_rp_checker.sv
`timescale 1ns/1ps
// Module: fpmul_rp_checker (top)
// Concurrent checker for a single-precision multiplier. It captures the
// operands and the claimed result on in_valid and reports a verdict one
// cycle later. Assumes CHK_BITS lies in 2..12 and the claimed mantissa is
// the unrounded product of the two 24-bit significands.
module fpmul_rp_checker
    import fpck_pkg::*;
#(
    parameter int CHK_BITS = 7,
    parameter int TOL      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              res_sign,
    input  logic [EXP_W-1:0]  res_exp,
    input  logic [PROD_W-1:0] res_mant,
    output logic              err_valid,
    output logic              err_flag
);
    localparam int WIN_W = CHK_BITS + 1;

    logic              cap_valid;
    logic [WORD_W-1:0] op_q [NUM_OPS];
    logic              sign_q;
    logic [EXP_W-1:0]  exp_q;
    logic              top_q;
    logic [WIN_W-1:0]  win_q;

    fp_fields_t          fields [NUM_OPS];
    logic [CHK_BITS-1:0] sig_hi [NUM_OPS];
    logic                res_special;
    logic                sign_bad;
    logic                exp_bad;
    logic                mant_bad;
    logic                check_on;
    logic                any_bad;

    // Input capture stage; only the mantissa window and top bit are kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            op_q[0]   <= '0;
            op_q[1]   <= '0;
            sign_q    <= 1'b0;
            exp_q     <= '0;
            top_q     <= 1'b0;
            win_q     <= '0;
        end else begin
            cap_valid <= in_valid;
            if (in_valid) begin
                op_q[0] <= op_a;
                op_q[1] <= op_b;
                sign_q  <= res_sign;
                exp_q   <= res_exp;
                top_q   <= res_mant[PROD_W-1];
                win_q   <= res_mant[PROD_W-1 -: WIN_W];
            end
        end
    end

    // One unpacker per operand.
    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_unp
        fpck_unpack #(.CHK_BITS(CHK_BITS)) u_unp (
            .word   (op_q[gi]),
            .fields (fields[gi]),
            .sig_hi (sig_hi[gi])
        );
    end

    fpck_sgn_exp_cmp u_se (
        .opa      (fields[0]),
        .opb      (fields[1]),
        .res_sign (sign_q),
        .res_exp  (exp_q),
        .top_bit  (top_q),
        .sign_bad (sign_bad),
        .exp_bad  (exp_bad)
    );

    fpck_mant_cmp #(.CHK_BITS(CHK_BITS), .TOL(TOL)) u_mc (
        .a_hi     (sig_hi[0]),
        .b_hi     (sig_hi[1]),
        .full_win (win_q),
        .mant_bad (mant_bad)
    );

    // Suppression of reserved encodings and merging of the three checks.
    always_comb begin
        res_special = (exp_q == '0) || (exp_q == '1);
        check_on    = !(fields[0].special || fields[1].special || res_special);
        any_bad     = check_on && (sign_bad || exp_bad || mant_bad);
    end

    // Verdict stage: one-cycle valid pulse with a qualified flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            err_valid <= cap_valid;
            err_flag  <= cap_valid && any_bad;
        end
    end
endmodule

// File: rtl/fpmul_rp_checker_sva.sv
`timescale 1ns/1ps
// Module: fpmul_rp_checker_sva
// Property checker bound to fpmul_rp_checker. It watches only the ports
// and works out its own sign and exponent expectations.
module fpmul_rp_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        res_sign,
    input logic [7:0]  res_exp,
    input logic        mant_top,
    input logic        err_valid,
    input logic        err_flag
);
    logic       all_normal;
    logic [9:0] exp_want;

    // Port-side view of the enable condition and the expected exponent.
    always_comb begin
        all_normal = (op_a[30:23] != 8'h00) && (op_a[30:23] != 8'hFF)
                  && (op_b[30:23] != 8'h00) && (op_b[30:23] != 8'hFF)
                  && (res_exp != 8'h00) && (res_exp != 8'hFF);
        exp_want   = {2'b00, op_a[30:23]} + {2'b00, op_b[30:23]}
                   + {9'd0, mant_top} - 10'd127;
    end

    p_verdict_due_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 err_valid);
    p_no_stray_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !err_valid);
    p_flag_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> err_valid);
    p_reset_clears_r3: assert property (@(posedge clk)
        !rst_n |=> (!err_valid && !err_flag));
    p_sign_caught_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && all_normal && (res_sign != (op_a[31] ^ op_b[31])))
        |-> ##2 err_flag);
    p_exp_caught_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && all_normal && ({2'b00, res_exp} != exp_want))
        |-> ##2 err_flag);
    p_special_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !all_normal) |-> ##2 !err_flag);
endmodule

bind fpmul_rp_checker fpmul_rp_checker_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .res_sign  (res_sign),
    .res_exp   (res_exp),
    .mant_top  (res_mant[47]),
    .err_valid (err_valid),
    .err_flag  (err_flag)
);

// File: tb/fpmul_rp_checker_tb.sv
`timescale 1ns/1ps
// Directed bench for fpmul_rp_checker: one task per scenario.
module fpmul_rp_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        res_sign = 1'b0;
    logic [7:0]  res_exp = '0;
    logic [47:0] res_mant = '0;
    logic        err_valid;
    logic        err_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    fpmul_rp_checker u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .res_sign(res_sign),
        .res_exp(res_exp), .res_mant(res_mant),
        .err_valid(err_valid), .err_flag(err_flag)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rand_op();
        logic [7:0] e = 8'(100 + $urandom_range(0, 54));
        return {1'($urandom), e, 23'($urandom)};
    endfunction

    task automatic ref_prod(input logic [31:0] a, input logic [31:0] b,
                            output logic s, output logic [7:0] e,
                            output logic [47:0] m);
        int ex;
        m  = 48'({1'b1, a[22:0]}) * 48'({1'b1, b[22:0]});
        s  = a[31] ^ b[31];
        ex = int'(a[30:23]) + int'(b[30:23]) - 127 + int'(m[47]);
        e  = 8'(ex);
    endtask

    // Present one multiply and return the verdict read after its due edge.
    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic s, input logic [7:0] e,
                         input logic [47:0] m,
                         output logic v, output logic f);
        @(negedge clk);
        op_a = a; op_b = b; res_sign = s; res_exp = e; res_mant = m;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        v = err_valid;
        f = err_flag;
    endtask

    task automatic t_reset();
        check("R3", "err_valid in reset", err_valid, 1'b0);
        check("R3", "err_flag in reset", err_flag, 1'b0);
    endtask

    task automatic t_clean();
        logic s, v, f; logic [7:0] e; logic [47:0] m;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a = rand_op();
            logic [31:0] b = rand_op();
            ref_prod(a, b, s, e, m);
            apply(a, b, s, e, m, v, f);
            check("R1", "clean verdict valid", v, 1'b1);
            check("R9", "clean product flag", f, 1'b0);
            @(negedge clk);
            check("R1", "pulse ends", err_valid, 1'b0);
            check("R2", "flag idle", err_flag, 1'b0);
        end
    endtask

    task automatic t_boundary();
        logic v, f;
        logic [47:0] base = 48'h4000_0000_0000;
        apply(32'h3F80_0000, 32'h3F80_0000, 1'b0, 8'd127, base, v, f);
        check("R6", "exact 1.0*1.0", f, 1'b0);
        apply(32'h3F80_0000, 32'h3F80_0000, 1'b0, 8'd127, base + (48'd7 << 40), v, f);
        check("R6", "window +7", f, 1'b0);
        apply(32'h3F80_0000, 32'h3F80_0000, 1'b0, 8'd127, base + (48'd8 << 40), v, f);
        check("R6", "window +8", f, 1'b1);
        apply(32'h3F80_0000, 32'h3F80_0000, 1'b0, 8'd127, base - (48'd7 << 40), v, f);
        check("R6", "window -7", f, 1'b0);
        apply(32'h3F80_0000, 32'h3F80_0000, 1'b0, 8'd127, base - (48'd8 << 40), v, f);
        check("R6", "window -8", f, 1'b1);
    endtask

    task automatic t_high_bits();
        logic s, v, f; logic [7:0] e; logic [47:0] m;
        for (int i = 0; i < 12; i++) begin
            logic [31:0] a = rand_op();
            logic [31:0] b = rand_op();
            int k = 44 + (i % 3);
            ref_prod(a, b, s, e, m);
            apply(a, b, s, e, m ^ (48'd1 << k), v, f);
            check("R6", $sformatf("high bit %0d flipped", k), f, 1'b1);
        end
    endtask

    task automatic t_low_bits();
        logic s, v, f; logic [7:0] e; logic [47:0] m;
        for (int i = 0; i < 12; i++) begin
            logic [31:0] a = rand_op();
            logic [31:0] b = rand_op();
            logic [47:0] junk = {8'h00, 8'($urandom), 32'($urandom)};
            ref_prod(a, b, s, e, m);
            apply(a, b, s, e, m ^ junk, v, f);
            check("R7", "low bits corrupted", f, 1'b0);
        end
    endtask

    task automatic t_sign();
        logic s, v, f; logic [7:0] e; logic [47:0] m;
        for (int i = 0; i < 6; i++) begin
            logic [31:0] a = rand_op();
            logic [31:0] b = rand_op();
            ref_prod(a, b, s, e, m);
            apply(a, b, ~s, e, m, v, f);
            check("R4", "sign flipped", f, 1'b1);
        end
    endtask

    task automatic t_exp();
        logic s, v, f; logic [7:0] e; logic [47:0] m;
        for (int i = 0; i < 6; i++) begin
            logic [31:0] a = rand_op();
            logic [31:0] b = rand_op();
            ref_prod(a, b, s, e, m);
            apply(a, b, s, (i % 2 == 0) ? e + 8'd1 : e - 8'd1, m, v, f);
            check("R5", "exponent off by one", f, 1'b1);
        end
    endtask

    task automatic t_special();
        logic v, f;
        logic [31:0] nrm = 32'h4040_0000;
        apply(32'h7F80_0000, nrm, 1'b1, 8'h55, 48'h1234_5678_9ABC, v, f);
        check("R8", "inf operand valid", v, 1'b1);
        check("R8", "inf operand flag", f, 1'b0);
        apply(nrm, 32'h7FC0_0001, 1'b1, 8'h55, 48'h0, v, f);
        check("R8", "NaN operand flag", f, 1'b0);
        apply(nrm, 32'h0001_2345, 1'b0, 8'h10, 48'hFFFF_0000_0000, v, f);
        check("R8", "denormal operand flag", f, 1'b0);
        apply(32'h0000_0000, nrm, 1'b1, 8'h80, 48'h0, v, f);
        check("R8", "zero operand flag", f, 1'b0);
        apply(nrm, nrm, 1'b1, 8'hFF, 48'h0, v, f);
        check("R8", "result exp 255 flag", f, 1'b0);
        apply(nrm, nrm, 1'b1, 8'h00, 48'h0, v, f);
        check("R8", "result exp 0 flag", f, 1'b0);
    endtask

    task automatic t_back_to_back();
        logic s1, s2; logic [7:0] e1, e2; logic [47:0] m1, m2;
        logic [31:0] a1 = rand_op(), b1 = rand_op(), a2 = rand_op(), b2 = rand_op();
        ref_prod(a1, b1, s1, e1, m1);
        ref_prod(a2, b2, s2, e2, m2);
        @(negedge clk);
        op_a = a1; op_b = b1; res_sign = s1; res_exp = e1; res_mant = m1;
        in_valid = 1'b1;
        @(negedge clk);
        op_a = a2; op_b = b2; res_sign = ~s2; res_exp = e2; res_mant = m2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "first of pair valid", err_valid, 1'b1);
        check("R1", "first of pair clean", err_flag, 1'b0);
        @(negedge clk);
        check("R1", "second of pair valid", err_valid, 1'b1);
        check("R4", "second of pair flagged", err_flag, 1'b1);
        @(negedge clk);
        check("R1", "pair pulse ends", err_valid, 1'b0);
    endtask

    task automatic t_reset_abort();
        logic s; logic [7:0] e; logic [47:0] m;
        logic [31:0] a = rand_op(), b = rand_op();
        ref_prod(a, b, s, e, m);
        @(negedge clk);
        op_a = a; op_b = b; res_sign = ~s; res_exp = e; res_mant = m;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R3", "aborted verdict valid", err_valid, 1'b0);
        check("R3", "aborted verdict flag", err_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "no verdict after abort", err_valid, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_clean();
        t_boundary();
        t_high_bits();
        t_low_bits();
        t_sign();
        t_exp();
        t_special();
        t_back_to_back();
        t_reset_abort();
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule